// File: doc/BRIEF.md
# Data Access Permission Checker

This block judges every data load or store before it reaches memory. For each request it takes the virtual address, the access size, a store flag, three request qualifiers and the processor mode state, along with the result of a translation lookup that has already been done elsewhere. It returns one of three things: a physical address, a classified fault code, or a memory-management status word that says why the access failed.

The block first picks an effective privilege mode. Privileged code may borrow an alternate mode for a single access. That mode then selects one bit from the entry's per-mode read or write enable mask. Requests flagged as physical skip translation. A fixed region of the virtual space maps directly to physical memory and is open only to kernel mode. Four saturating counters record read violations, write violations, read misses and write misses. The response is registered and appears one cycle after the request.

Top module: `dacc_guard`

## Requirements
- R1: Each cycle with `req_valid` high is followed, exactly one clock later, by one cycle with `rsp_valid` high. No `rsp_valid` appears after a cycle with `req_valid` low.
- R2: An access whose `req_vaddr[2:0]` has any bit set within the low `req_size` bits (the access is 2^`req_size` bytes) is misaligned. It gives fault code 1 whatever the other inputs are, and its status holds only the write bit (bit 0), and that bit only for a store.
- R3: An aligned request with `req_phys` set gives fault code 0, status 0 and `rsp_paddr` equal to `req_vaddr[PA_W-1:0]`.
- R4: In an aligned, non-physical request whose region field `req_vaddr[47:41]` equals 0x7E, a `cur_mode` of kernel (0) gives `rsp_paddr` = `req_vaddr[PA_W-1:0]` with no fault. Any other `cur_mode` gives fault code 2 (access violation), with status bit 1 plus bit 0 for a store.
- R5: Otherwise a request with `tlb_hit` low faults with code 5 when `req_pte` is set and code 4 when it is not. Its status holds the miss bit (bit 4), plus bit 0 for a store.
- R6: The effective mode is `alt_mode` when both `priv_code` and `req_alt` are set, kernel (0) when `priv_code` is set without `req_alt`, and `cur_mode` when `priv_code` is clear. Modes are kernel=0, executive=1, supervisor=2, user=3. Permission for mode m is bit m of `tlb_rd_en` or `tlb_wr_en`.
- R7: A store that hits but is not permitted gives fault code 3 (page fault) with status bits 0 and 1, plus bit 3 when `tlb_fonw` is set. A permitted store with `tlb_fonw` set gives code 3 with status bits 0 and 3.
- R8: A load that hits but is not permitted gives code 2 with status bit 1, plus bit 2 when `tlb_fonr` is set. A permitted load with `tlb_fonr` set gives code 3 with status bit 2.
- R9: A permitted hit with no fault-on bit set gives code 0, status 0 and `rsp_paddr` = {`tlb_ppn`, `req_vaddr[12:0]`}. Every faulting response drives `rsp_paddr` to 0.
- R10: After reset all four counters read 0. Each faulting request with code 2 or 3 adds one to the read- or write-violation counter, chosen by its direction. Each request with code 4 or 5 adds one to the read- or write-miss counter. The counters change on the edge that raises `rsp_valid` and stop at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | log2 of access size in bytes |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Use alternate mode when in privileged code |
| req_pte | input | 1 | Access is a page-table-entry fetch |
| cur_mode | input | 2 | Current-mode register |
| alt_mode | input | 2 | Alternate-mode register |
| priv_code | input | 1 | Request issued from privileged code |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_ppn | input | PA_W-OFS_W | Physical page number of entry |
| tlb_rd_en | input | 4 | Per-mode read enable mask |
| tlb_wr_en | input | 4 | Per-mode write enable mask |
| tlb_fonr | input | 1 | Entry faults on read |
| tlb_fonw | input | 1 | Entry faults on write |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 3 | Fault code (0 none, 1 align, 2 violation, 3 page, 4 native miss, 5 table miss) |
| rsp_status | output | 5 | Status: bit0 write, bit1 violation, bit2 fault-on-read, bit3 fault-on-write, bit4 miss |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| cnt_rd_acv | output | CNT_W | Read violation count |
| cnt_wr_acv | output | CNT_W | Write violation count |
| cnt_rd_miss | output | CNT_W | Read miss count |
| cnt_wr_miss | output | CNT_W | Write miss count |

## Verification
Some properties hold on every cycle, and the assertions check those. They cover the one-cycle request-to-response timing and the zero address on every fault. They check that a clean response carries a zero status, that a violation always sets the violation bit and a miss always sets the miss bit, and that no counter ever goes down. The fault priority can only be shown by the bench's scenarios, which stack conditions so that a higher rule must win. The same holds for the effective-mode choice between the current and alternate registers, for the exact fault-on bits in each status word, and for counters stopping at their limit.

// File: rtl/dacc_guard_pkg.sv
package dacc_guard_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_ACV   = 3'd2,
    FLT_PAGE  = 3'd3,
    FLT_NMISS = 3'd4,
    FLT_PMISS = 3'd5
  } flt_e;

  localparam int ST_W    = 5;
  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_FONR = 2;
  localparam int ST_FONW = 3;
  localparam int ST_MISS = 4;

  localparam logic [1:0] MODE_KERN = 2'd0;

  // Mode used for the permission lookup.
  function automatic logic [1:0] pick_mode(input logic priv, input logic use_alt,
                                           input logic [1:0] alt_m, input logic [1:0] cur_m);
    if (!priv) return cur_m;
    return use_alt ? alt_m : MODE_KERN;
  endfunction

  // True when the low address bits are not a multiple of 2^size bytes.
  function automatic logic misaligned(input logic [2:0] low, input logic [1:0] size);
    logic [3:0] m;
    m = (4'd1 << size) - 4'd1;
    return |(low & m[2:0]);
  endfunction

endpackage

// File: rtl/dacc_perm.sv
module dacc_perm
  import dacc_guard_pkg::*;
(
  input  logic       priv_code,
  input  logic       req_alt,
  input  logic [1:0] alt_mode,
  input  logic [1:0] cur_mode,
  input  logic       req_write,
  input  logic [3:0] rd_en,
  input  logic [3:0] wr_en,
  output logic [1:0] eff_mode,
  output logic       perm_ok
);

  always_comb begin
    eff_mode = pick_mode(priv_code, req_alt, alt_mode, cur_mode);
    perm_ok  = req_write ? wr_en[eff_mode] : rd_en[eff_mode];
  end

endmodule

// File: rtl/dacc_classify.sv
module dacc_classify
  import dacc_guard_pkg::*;
#(
  parameter int               VA_W       = 48,
  parameter int               PA_W       = 44,
  parameter int               OFS_W      = 13,
  parameter int               REG_W      = 7,
  parameter logic [REG_W-1:0] SUPER_CODE = 7'h7E,
  localparam int              PPN_W      = PA_W - OFS_W
)(
  input  logic [VA_W-1:0]  vaddr,
  input  logic             write,
  input  logic [1:0]       size,
  input  logic             phys,
  input  logic             pte,
  input  logic [1:0]       cur_mode,
  input  logic             hit,
  input  logic [PPN_W-1:0] ppn,
  input  logic             perm_ok,
  input  logic             fonr,
  input  logic             fonw,
  output logic [2:0]       fault,
  output logic [ST_W-1:0]  status,
  output logic [PA_W-1:0]  paddr
);

  logic [REG_W-1:0] region;
  logic             is_super;
  flt_e             f;

  assign region   = vaddr[VA_W-1 -: REG_W];
  assign is_super = (region == SUPER_CODE);

  always_comb begin
    f      = FLT_NONE;
    status = '0;
    paddr  = '0;
    if (misaligned(vaddr[2:0], size)) begin
      f             = FLT_ALIGN;
      status[ST_WR] = write;
    end else if (phys) begin
      paddr = vaddr[PA_W-1:0];
    end else if (is_super) begin
      if (cur_mode != MODE_KERN) begin
        f              = FLT_ACV;
        status[ST_ACV] = 1'b1;
        status[ST_WR]  = write;
      end else begin
        paddr = vaddr[PA_W-1:0];
      end
    end else if (!hit) begin
      f               = pte ? FLT_PMISS : FLT_NMISS;
      status[ST_MISS] = 1'b1;
      status[ST_WR]   = write;
    end else if (write) begin
      if (!perm_ok || fonw) begin
        f               = FLT_PAGE;
        status[ST_WR]   = 1'b1;
        status[ST_ACV]  = !perm_ok;
        status[ST_FONW] = fonw;
      end else begin
        paddr = {ppn, vaddr[OFS_W-1:0]};
      end
    end else begin
      if (!perm_ok) begin
        f               = FLT_ACV;
        status[ST_ACV]  = 1'b1;
        status[ST_FONR] = fonr;
      end else if (fonr) begin
        f               = FLT_PAGE;
        status[ST_FONR] = 1'b1;
      end else begin
        paddr = {ppn, vaddr[OFS_W-1:0]};
      end
    end
    fault = f;
  end

endmodule

// File: rtl/dacc_sat_cnt.sv
module dacc_sat_cnt #(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                      count <= '0;
    else if (inc && count != MAXV)   count <= count + 1'b1;
  end

endmodule

// File: rtl/dacc_guard.sv
module dacc_guard
  import dacc_guard_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 44,
  parameter int OFS_W = 13,
  parameter int CNT_W = 16,
  localparam int PPN_W = PA_W - OFS_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic             req_phys,
  input  logic             req_alt,
  input  logic             req_pte,
  input  logic [1:0]       cur_mode,
  input  logic [1:0]       alt_mode,
  input  logic             priv_code,
  input  logic             tlb_hit,
  input  logic [PPN_W-1:0] tlb_ppn,
  input  logic [3:0]       tlb_rd_en,
  input  logic [3:0]       tlb_wr_en,
  input  logic             tlb_fonr,
  input  logic             tlb_fonw,
  output logic             rsp_valid,
  output logic [2:0]       rsp_fault,
  output logic [4:0]       rsp_status,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [CNT_W-1:0] cnt_rd_acv,
  output logic [CNT_W-1:0] cnt_wr_acv,
  output logic [CNT_W-1:0] cnt_rd_miss,
  output logic [CNT_W-1:0] cnt_wr_miss
);

  localparam int N_CNT = 4;

  logic [1:0]      eff_mode;
  logic            perm_ok;
  logic [2:0]      c_fault;
  logic [ST_W-1:0] c_status;
  logic [PA_W-1:0] c_paddr;

  // Named events, one per counter.
  logic ev_viol, ev_miss;
  logic ev_rd_acv, ev_wr_acv, ev_rd_miss, ev_wr_miss;
  logic [N_CNT-1:0] ev_vec;
  logic [CNT_W-1:0] cnt_arr [N_CNT];

  dacc_perm u_perm (
    .priv_code (priv_code),
    .req_alt   (req_alt),
    .alt_mode  (alt_mode),
    .cur_mode  (cur_mode),
    .req_write (req_write),
    .rd_en     (tlb_rd_en),
    .wr_en     (tlb_wr_en),
    .eff_mode  (eff_mode),
    .perm_ok   (perm_ok)
  );

  dacc_classify #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_cls (
    .vaddr    (req_vaddr),
    .write    (req_write),
    .size     (req_size),
    .phys     (req_phys),
    .pte      (req_pte),
    .cur_mode (cur_mode),
    .hit      (tlb_hit),
    .ppn      (tlb_ppn),
    .perm_ok  (perm_ok),
    .fonr     (tlb_fonr),
    .fonw     (tlb_fonw),
    .fault    (c_fault),
    .status   (c_status),
    .paddr    (c_paddr)
  );

  assign ev_viol    = req_valid && (c_fault == FLT_ACV || c_fault == FLT_PAGE);
  assign ev_miss    = req_valid && (c_fault == FLT_NMISS || c_fault == FLT_PMISS);
  assign ev_rd_acv  = ev_viol && !req_write;
  assign ev_wr_acv  = ev_viol &&  req_write;
  assign ev_rd_miss = ev_miss && !req_write;
  assign ev_wr_miss = ev_miss &&  req_write;
  assign ev_vec     = {ev_wr_miss, ev_rd_miss, ev_wr_acv, ev_rd_acv};

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    dacc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev_vec[i]),
      .count (cnt_arr[i])
    );
  end

  assign cnt_rd_acv  = cnt_arr[0];
  assign cnt_wr_acv  = cnt_arr[1];
  assign cnt_rd_miss = cnt_arr[2];
  assign cnt_wr_miss = cnt_arr[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= '0;
      rsp_status <= '0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_fault  <= req_valid ? c_fault  : '0;
      rsp_status <= req_valid ? c_status : '0;
      rsp_paddr  <= req_valid ? c_paddr  : '0;
    end
  end

endmodule

// File: rtl/dacc_guard_chk.sv
module dacc_guard_chk #(
  parameter int PA_W  = 44,
  parameter int CNT_W = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic [2:0]       rsp_fault,
  input logic [4:0]       rsp_status,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [CNT_W-1:0] cnt_rd_acv,
  input logic [CNT_W-1:0] cnt_wr_acv,
  input logic [CNT_W-1:0] cnt_rd_miss,
  input logic [CNT_W-1:0] cnt_wr_miss
);

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_fault_zero_paddr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == '0);

  assert_clean_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd0) |-> rsp_status == 5'd0);

  assert_miss_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5)) |-> (rsp_status[4] && !rsp_status[1]));

  assert_acv_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd2) |-> rsp_status[1]);

  assert_cnt_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt_rd_acv >= $past(cnt_rd_acv) && cnt_wr_acv >= $past(cnt_wr_acv) &&
                      cnt_rd_miss >= $past(cnt_rd_miss) && cnt_wr_miss >= $past(cnt_wr_miss)));

endmodule

bind dacc_guard dacc_guard_chk #(.PA_W(PA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .rsp_valid   (rsp_valid),
  .rsp_fault   (rsp_fault),
  .rsp_status  (rsp_status),
  .rsp_paddr   (rsp_paddr),
  .cnt_rd_acv  (cnt_rd_acv),
  .cnt_wr_acv  (cnt_wr_acv),
  .cnt_rd_miss (cnt_rd_miss),
  .cnt_wr_miss (cnt_wr_miss)
);

// File: tb/dacc_guard_tb.sv
module dacc_guard_tb;

  localparam int VA_W  = 48;
  localparam int PA_W  = 44;
  localparam int OFS_W = 13;
  localparam int CNT_W = 3;
  localparam int PPN_W = PA_W - OFS_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    logic [VA_W-1:0]  va;
    logic             wr;
    logic [1:0]       size;
    logic             phys, alt, pte;
    logic [1:0]       cur, altm;
    logic             priv, hit;
    logic [PPN_W-1:0] ppn;
    logic [3:0]       rden, wren;
    logic             fonr, fonw;
  } req_t;

  typedef struct {
    string            tag;
    logic [2:0]       fault;
    logic [4:0]       status;
    logic [PA_W-1:0]  paddr;
    logic [CNT_W-1:0] cnt [4];
  } item_t;

  logic             req_valid = 1'b0;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic             req_write = 1'b0;
  logic [1:0]       req_size = '0;
  logic             req_phys = 1'b0, req_alt = 1'b0, req_pte = 1'b0;
  logic [1:0]       cur_mode = '0, alt_mode = '0;
  logic             priv_code = 1'b0, tlb_hit = 1'b0;
  logic [PPN_W-1:0] tlb_ppn = '0;
  logic [3:0]       tlb_rd_en = '0, tlb_wr_en = '0;
  logic             tlb_fonr = 1'b0, tlb_fonw = 1'b0;

  logic             rsp_valid;
  logic [2:0]       rsp_fault;
  logic [4:0]       rsp_status;
  logic [PA_W-1:0]  rsp_paddr;
  logic [CNT_W-1:0] cnt_rd_acv, cnt_wr_acv, cnt_rd_miss, cnt_wr_miss;

  dacc_guard #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_size(req_size), .req_phys(req_phys),
    .req_alt(req_alt), .req_pte(req_pte), .cur_mode(cur_mode), .alt_mode(alt_mode),
    .priv_code(priv_code), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr),
    .tlb_fonw(tlb_fonw), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .cnt_rd_acv(cnt_rd_acv),
    .cnt_wr_acv(cnt_wr_acv), .cnt_rd_miss(cnt_rd_miss), .cnt_wr_miss(cnt_wr_miss)
  );

  int n_chk = 0, n_bad = 0;
  item_t sb[$];
  logic [CNT_W-1:0] ecnt [4] = '{default: '0};

  task automatic check(input bit ok, input string what, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  function automatic req_t base();
    req_t r;
    r.va = 48'h0000_1234_5678; r.wr = 0; r.size = 2'd3;
    r.phys = 0; r.alt = 0; r.pte = 0; r.cur = 2'd0; r.altm = 2'd0;
    r.priv = 0; r.hit = 1; r.ppn = 31'h1ABC_DEF0;
    r.rden = 4'hF; r.wren = 4'hF; r.fonr = 0; r.fonw = 0;
    return r;
  endfunction

  // Independent reference built from the requirement text.
  function automatic void model(input req_t r, output logic [2:0] f,
                                output logic [4:0] s, output logic [PA_W-1:0] pa);
    logic [1:0] m;
    logic allow, bad_align;
    f = 3'd0; s = 5'd0; pa = '0;
    case (r.size)
      2'd0: bad_align = 1'b0;
      2'd1: bad_align = r.va[0];
      2'd2: bad_align = r.va[1] | r.va[0];
      default: bad_align = r.va[2:0] != 3'b000;
    endcase
    m = r.priv ? (r.alt ? r.altm : 2'd0) : r.cur;
    allow = r.wr ? r.wren[m] : r.rden[m];
    if (bad_align) begin f = 3'd1; s = {4'b0, r.wr}; end
    else if (r.phys) pa = r.va[PA_W-1:0];
    else if (r.va[47:41] == 7'h7E) begin
      if (r.cur == 2'd0) pa = r.va[PA_W-1:0];
      else begin f = 3'd2; s = {3'b0, 1'b1, r.wr}; end
    end
    else if (!r.hit) begin f = r.pte ? 3'd5 : 3'd4; s = {1'b1, 3'b0, r.wr}; end
    else if (r.wr && !allow) begin f = 3'd3; s = {1'b0, r.fonw, 1'b0, 1'b1, 1'b1}; end
    else if (r.wr && r.fonw) begin f = 3'd3; s = 5'b01001; end
    else if (!r.wr && !allow) begin f = 3'd2; s = {2'b0, r.fonr, 1'b1, 1'b0}; end
    else if (!r.wr && r.fonr) begin f = 3'd3; s = 5'b00100; end
    else pa = {r.ppn, r.va[OFS_W-1:0]};
  endfunction

  task automatic send(input req_t r, input string tag);
    item_t it;
    int k;
    @(negedge clk);
    model(r, it.fault, it.status, it.paddr);
    k = -1;
    if (it.fault == 3'd2 || it.fault == 3'd3) k = r.wr ? 1 : 0;
    if (it.fault == 3'd4 || it.fault == 3'd5) k = r.wr ? 3 : 2;
    if (k >= 0 && ecnt[k] != CMAX) ecnt[k] = ecnt[k] + 1'b1;
    it.cnt = ecnt;
    it.tag = tag;
    sb.push_back(it);
    req_valid = 1'b1; req_vaddr = r.va; req_write = r.wr; req_size = r.size;
    req_phys = r.phys; req_alt = r.alt; req_pte = r.pte; cur_mode = r.cur;
    alt_mode = r.altm; priv_code = r.priv; tlb_hit = r.hit; tlb_ppn = r.ppn;
    tlb_rd_en = r.rden; tlb_wr_en = r.wren; tlb_fonr = r.fonr; tlb_fonw = r.fonw;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) check(0, "R1 unexpected rsp_valid", "1", "0");
      else begin
        item_t e;
        e = sb.pop_front();
        check(rsp_fault == e.fault, {e.tag, " fault"}, $sformatf("%0d", rsp_fault), $sformatf("%0d", e.fault));
        check(rsp_status == e.status, {e.tag, " status"}, $sformatf("%b", rsp_status), $sformatf("%b", e.status));
        check(rsp_paddr == e.paddr, {e.tag, " paddr"}, $sformatf("%h", rsp_paddr), $sformatf("%h", e.paddr));
        check({cnt_wr_miss, cnt_rd_miss, cnt_wr_acv, cnt_rd_acv} == {e.cnt[3], e.cnt[2], e.cnt[1], e.cnt[0]},
              {e.tag, " R10 counters"},
              $sformatf("%0d/%0d/%0d/%0d", cnt_rd_acv, cnt_wr_acv, cnt_rd_miss, cnt_wr_miss),
              $sformatf("%0d/%0d/%0d/%0d", e.cnt[0], e.cnt[1], e.cnt[2], e.cnt[3]));
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    req_t r;
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && cnt_rd_acv == 0 && cnt_wr_acv == 0 && cnt_rd_miss == 0 && cnt_wr_miss == 0,
          "R10 reset state", $sformatf("%b", rsp_valid), "0");
    rst_n = 1'b1;
    idle(2);
    check(rsp_valid == 0, "R1 idle no response", $sformatf("%b", rsp_valid), "0");

    // R9 plain hits, load and store
    r = base(); send(r, "R9 load hit");
    r = base(); r.wr = 1; r.va = 48'h0000_0000_1FF8; send(r, "R9 store hit");
    // R3 physical, bypasses miss
    r = base(); r.phys = 1; r.hit = 0; r.va = 48'h7654_3210_ABC0; send(r, "R3 physical");
    // R4 superpage
    r = base(); r.va = 48'hFC12_3456_7890; r.hit = 0; send(r, "R4 superpage kernel");
    r = base(); r.va = 48'hFC12_3456_7890; r.cur = 2'd3; r.wr = 1; send(r, "R4 superpage user store");
    r = base(); r.va = 48'hFC12_3456_7890; r.cur = 2'd1; send(r, "R4 superpage exec load");
    // R5 misses
    r = base(); r.hit = 0; send(r, "R5 native load miss");
    r = base(); r.hit = 0; r.pte = 1; r.wr = 1; send(r, "R5 table store miss");
    // R2 alignment beats everything
    r = base(); r.va = 48'hFC00_0000_0004; r.cur = 2'd3; r.wr = 1; send(r, "R2 misaligned quad store");
    r = base(); r.va = 48'h0000_0000_0001; r.size = 2'd1; r.hit = 0; send(r, "R2 misaligned word load");
    r = base(); r.va = 48'h0000_0000_0003; r.size = 2'd0; send(r, "R2 byte never misaligned");
    // R7 stores
    r = base(); r.wr = 1; r.cur = 2'd2; r.wren = 4'b1011; r.fonw = 1; send(r, "R7 store denied fonw");
    r = base(); r.wr = 1; r.cur = 2'd2; r.wren = 4'b1011; send(r, "R7 store denied");
    r = base(); r.wr = 1; r.fonw = 1; send(r, "R7 store fonw");
    // R8 loads
    r = base(); r.cur = 2'd3; r.rden = 4'b0111; r.fonr = 1; send(r, "R8 load denied fonr");
    r = base(); r.cur = 2'd3; r.rden = 4'b0111; send(r, "R8 load denied");
    r = base(); r.fonr = 1; send(r, "R8 load fonr");
    // R6 effective mode
    r = base(); r.priv = 1; r.alt = 1; r.altm = 2'd3; r.cur = 2'd0; r.rden = 4'b0111; send(r, "R6 alt user denied");
    r = base(); r.priv = 1; r.alt = 0; r.altm = 2'd3; r.cur = 2'd3; r.rden = 4'b0001; send(r, "R6 priv kernel allowed");
    r = base(); r.priv = 0; r.alt = 1; r.altm = 2'd0; r.cur = 2'd1; r.rden = 4'b0001; send(r, "R6 nonpriv cur denied");
    idle(1);
    // back-to-back with a gap: R1
    r = base(); send(r, "R1 after gap");
    idle(3);
    check(rsp_valid == 0 && sb.size() == 0, "R1 drained", $sformatf("%0d", sb.size()), "0");
    // R10 saturation
    for (int i = 0; i < 10; i++) begin
      r = base(); r.hit = 0; send(r, "R10 read miss saturate");
    end
    idle(2);
    check(cnt_rd_miss == CMAX, "R10 saturated", $sformatf("%0d", cnt_rd_miss), $sformatf("%0d", CMAX));
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule